// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that runs a short list of prepared transfers without help from software. Software fills up to sixteen queue slots through a small byte-wide register bus. Each slot holds a transmit word, a receive word and a command byte. Software then writes a first and a last slot index and sets the run bit. The engine walks the slots in order and shifts each word out MSB first on SCK and MOSI. It drives four active-low chip selects from each slot's command byte and writes the bits it samples on MISO back into that slot's receive word.

When the last slot has finished, the engine sets a completion flag that software clears. It can also raise an interrupt line. The SCK rate, word width and clock polarity/phase are programmable. A command bit on each slot decides whether the chip select stays low into the next slot or is released between slots.

Top module: `spi_queue_master`

## Requirements
- R1: After reset the mode register reads 0xA3 (master, 8-bit field, CPOL=1, CPHA=1), SCK idles high, cs_n is 4'hF, status reads 0 and irq is low.
- R2: Register map (byte addresses, data in bits 7:0): divisor 0x000, mode 0x004, first slot 0x010, last slot 0x014, control 0x018, status 0x020. Slot s transmit word: high byte at 0x040+8s, low byte at 0x044+8s. Slot s receive word: the same layout at 0x0C0. Slot s command byte: 0x140+4s. Words shift MSB first.
- R3: A run executes slots from the first index through the last index, both included, and the index wraps from 15 to 0.
- R4: Command byte: bit 7 = keep chip select asserted after the slot, bit 6 = 16-bit word, bits 3:0 = the value driven on cs_n (active low) for the whole slot.
- R5: After a slot whose keep bit is clear, cs_n returns to 4'hF. If more slots follow, cs_n stays high for at least one SCK period (2×divisor clocks) before the next slot.
- R6: If the last slot of a run has its keep bit set, cs_n keeps that slot's value after the run completes.
- R7: One SCK period lasts 2×divisor system clocks. Divisor values below 8 act as 8.
- R8: Mode bit 1 (CPOL) sets the SCK idle level. With mode bit 0 (CPHA) at 0, data is sampled on the leading SCK edge; with CPHA at 1, on the trailing edge. The received bits are stored into the slot's receive word.
- R9: Word width is 16 bits when command bit 6 is set. Otherwise it comes from mode bits 5:2: 0 gives 16, 1 to 7 give 8, and 8 to 15 give that many bits. A receive word of n bits is right-aligned, with the unused upper bits zero. A transmit word sends its low n bits.
- R10: Control bit 6 (run), when written as 1 while idle, starts a run. It reads back as 0 once the run completes. Status bit 1 reads 1 while slots execute.
- R11: Status bit 0 is set when a run completes. irq equals status bit 0 AND control bit 5. Writing 0 to status bit 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The checks assume that software does not rewrite the divisor, the mode or the slot pointers while a run is in progress. They also assume that MISO changes only on the slave's shift edges, never on the edge where the master samples. The bench keeps to this: it waits for the completion flag before touching any configuration. Its slave model updates MISO only on the opposite SCK edge from the one on which it captures MOSI.

// File: rtl/spi_q_pkg.sv
// Shared constants, types and helpers for the queued SPI master.
// Assumes byte-wide registers on a 9-bit byte address space.
package spi_q_pkg;
    localparam int NSLOT    = 16;
    localparam int SLOTW    = $clog2(NSLOT);
    localparam int AW       = 9;
    localparam int DIVW     = 8;
    localparam int MIN_DIV  = 8;
    localparam int WMAX     = 16;
    localparam int CNTW     = $clog2(WMAX) + 1;

    localparam logic [AW-1:0] OFF_DIV   = 9'h000;
    localparam logic [AW-1:0] OFF_MODE  = 9'h004;
    localparam logic [AW-1:0] OFF_FIRST = 9'h010;
    localparam logic [AW-1:0] OFF_LAST  = 9'h014;
    localparam logic [AW-1:0] OFF_CTRL  = 9'h018;
    localparam logic [AW-1:0] OFF_STAT  = 9'h020;
    localparam logic [AW-1:0] TX_BASE   = 9'h040;
    localparam logic [AW-1:0] RX_BASE   = 9'h0C0;
    localparam logic [AW-1:0] CMD_BASE  = 9'h140;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_SHIFT, S_DONE, S_GAP
    } eng_state_t;

    // Word width from the slot's wide bit and the mode width field.
    function automatic logic [CNTW-1:0] word_bits(input logic wide,
                                                    input logic [3:0] fld);
        if (wide || fld == 4'd0) return CNTW'(WMAX);
        else if (fld < 4'd8)     return CNTW'(8);
        else                     return CNTW'(fld);
    endfunction
endpackage

// File: rtl/spi_q_regs.sv
// Register file and slot storage for the queued SPI master.
// Holds configuration, per-slot transmit/receive/command bytes and
// the completion flag. Assumes single-cycle byte writes; reads are
// combinational from the address.
module spi_q_regs
    import spi_q_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              eng_busy,
    input  logic              eng_fin,
    input  logic              rx_we,
    input  logic [SLOTW-1:0]  rx_slot,
    input  logic [WMAX-1:0]   rx_word,
    input  logic [SLOTW-1:0]  eng_slot,
    output logic [WMAX-1:0]   tx_word,
    output logic [7:0]        cmd_byte,
    output logic [DIVW-1:0]   div_q,
    output logic [7:0]        mode_q,
    output logic [SLOTW-1:0]  first_q,
    output logic [SLOTW-1:0]  last_q,
    output logic              go,
    output logic              run_spe,
    output logic              run_done,
    output logic              irq
);
    logic [7:0] tx_hi [NSLOT];
    logic [7:0] tx_lo [NSLOT];
    logic [7:0] rx_hi [NSLOT];
    logic [7:0] rx_lo [NSLOT];
    logic [7:0] cmd_m [NSLOT];
    logic       cont_q, ie_q;

    logic [AW-1:0] tx_off, rx_off, cmd_off;
    logic          in_tx, in_rx, in_cmd;
    logic [SLOTW-1:0] tx_s, rx_s, cmd_s;

    // Decode the slot regions from the address.
    always_comb begin
        tx_off  = reg_addr - TX_BASE;
        rx_off  = reg_addr - RX_BASE;
        cmd_off = reg_addr - CMD_BASE;
        in_tx   = (tx_off  < AW'(NSLOT*8)) && (tx_off[1:0]  == 2'b00);
        in_rx   = (rx_off  < AW'(NSLOT*8)) && (rx_off[1:0]  == 2'b00);
        in_cmd  = (cmd_off < AW'(NSLOT*4)) && (cmd_off[1:0] == 2'b00);
        tx_s    = tx_off[SLOTW+2:3];
        rx_s    = rx_off[SLOTW+2:3];
        cmd_s   = cmd_off[SLOTW+1:2];
    end

    assign go = reg_we && (reg_addr == OFF_CTRL) && reg_wdata[6] && !eng_busy && !run_spe;

    // Per-slot storage, one register group per slot.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Software writes transmit and command bytes; engine writes receive.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tx_hi[s] <= '0;
                tx_lo[s] <= '0;
                rx_hi[s] <= '0;
                rx_lo[s] <= '0;
                cmd_m[s] <= '0;
            end else begin
                if (reg_we && in_tx && tx_s == SLOTW'(s)) begin
                    if (tx_off[2]) tx_lo[s] <= reg_wdata;
                    else           tx_hi[s] <= reg_wdata;
                end
                if (reg_we && in_cmd && cmd_s == SLOTW'(s))
                    cmd_m[s] <= reg_wdata;
                if (rx_we && rx_slot == SLOTW'(s))
                    {rx_hi[s], rx_lo[s]} <= rx_word;
            end
        end
    end

    // Configuration, control and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= DIVW'(MIN_DIV);
            mode_q   <= 8'hA3;
            first_q  <= '0;
            last_q   <= '0;
            cont_q   <= 1'b0;
            run_spe  <= 1'b0;
            ie_q     <= 1'b0;
            run_done <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    OFF_DIV:   div_q   <= reg_wdata;
                    OFF_MODE:  mode_q  <= reg_wdata;
                    OFF_FIRST: first_q <= reg_wdata[SLOTW-1:0];
                    OFF_LAST:  last_q  <= reg_wdata[SLOTW-1:0];
                    OFF_CTRL: begin
                        cont_q <= reg_wdata[7];
                        ie_q   <= reg_wdata[5];
                        if (go) run_spe <= 1'b1;
                    end
                    OFF_STAT:  run_done <= run_done & reg_wdata[0];
                    default: ;
                endcase
            end
            if (eng_fin) begin
                run_spe  <= 1'b0;
                run_done <= 1'b1;
            end
        end
    end

    assign irq      = run_done && ie_q;
    assign tx_word  = {tx_hi[eng_slot], tx_lo[eng_slot]};
    assign cmd_byte = cmd_m[eng_slot];

    // Read data multiplexer.
    always_comb begin
        reg_rdata = 8'h00;
        if (in_tx)       reg_rdata = tx_off[2] ? tx_lo[tx_s] : tx_hi[tx_s];
        else if (in_rx)  reg_rdata = rx_off[2] ? rx_lo[rx_s] : rx_hi[rx_s];
        else if (in_cmd) reg_rdata = cmd_m[cmd_s];
        else begin
            case (reg_addr)
                OFF_DIV:   reg_rdata = div_q;
                OFF_MODE:  reg_rdata = mode_q;
                OFF_FIRST: reg_rdata = 8'(first_q);
                OFF_LAST:  reg_rdata = 8'(last_q);
                OFF_CTRL:  reg_rdata = {cont_q, run_spe, ie_q, 5'b0};
                OFF_STAT:  reg_rdata = {6'b0, eng_busy, run_done};
                default:   reg_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/spi_q_baud.sv
// Half-period tick generator for SCK. Emits one tick every
// max(divisor, MIN_DIV) clocks while run is high; restarts when run drops.
module spi_q_baud
    import spi_q_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div_raw,
    output logic            tick
);
    logic [DIVW-1:0] cnt_q;
    logic [DIVW-1:0] div_eff;

    assign div_eff = (div_raw < DIVW'(MIN_DIV)) ? DIVW'(MIN_DIV) : div_raw;
    assign tick    = run && (cnt_q == div_eff - DIVW'(1));

    // Count clocks within one SCK half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + DIVW'(1);
    end
endmodule

// File: rtl/spi_q_engine.sv
// Slot sequencer, shift register and chip-select driver.
// Walks slots from first to last index, serializes each word MSB first
// using half-period ticks, and writes the received word back.
// Assumes mode and pointers stay constant during a run.
module spi_q_engine
    import spi_q_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [SLOTW-1:0] first_ptr,
    input  logic [SLOTW-1:0] last_ptr,
    input  logic [5:0]       mode,
    input  logic [WMAX-1:0]  tx_word,
    input  logic [7:0]       cmd_byte,
    input  logic             tick,
    input  logic             miso,
    output logic             run,
    output logic [SLOTW-1:0] slot,
    output logic             rx_we,
    output logic [WMAX-1:0]  rx_word,
    output logic             fin,
    output logic             busy,
    output logic             sck_int,
    output logic             mosi,
    output logic [3:0]       cs_n
);
    eng_state_t      state;
    logic            keep_q;
    logic [CNTW-1:0] nbits_q;
    logic [CNTW-1:0] edge_q;
    logic [WMAX-1:0] txsh, rxsh;
    logic            gap_q;
    logic [CNTW-1:0] nb_new;
    logic            samp, shf, last_edge;

    // Width of the slot about to load and edge classification.
    always_comb begin
        nb_new    = word_bits(cmd_byte[6], mode[5:2]);
        samp      = mode[0] ? edge_q[0] : !edge_q[0];
        shf       = !samp && (edge_q != '0);
        last_edge = ({1'b0, edge_q} == ({nbits_q, 1'b0} - (CNTW+1)'(1)));
    end

    // Sequencer state, shifters and chip selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            slot    <= '0;
            keep_q  <= 1'b0;
            nbits_q <= CNTW'(8);
            edge_q  <= '0;
            txsh    <= '0;
            rxsh    <= '0;
            gap_q   <= 1'b0;
            sck_int <= 1'b0;
            cs_n    <= 4'hF;
        end else begin
            case (state)
                S_IDLE: begin
                    sck_int <= 1'b0;
                    if (go) begin
                        slot  <= first_ptr;
                        state <= S_LOAD;
                    end
                end
                S_LOAD: begin
                    keep_q  <= cmd_byte[7];
                    nbits_q <= nb_new;
                    txsh    <= tx_word << (CNTW'(WMAX) - nb_new);
                    rxsh    <= '0;
                    cs_n    <= cmd_byte[3:0];
                    edge_q  <= '0;
                    sck_int <= 1'b0;
                    state   <= S_SHIFT;
                end
                S_SHIFT: begin
                    if (tick) begin
                        sck_int <= !sck_int;
                        if (samp) rxsh <= {rxsh[WMAX-2:0], miso};
                        if (shf)  txsh <= {txsh[WMAX-2:0], 1'b0};
                        edge_q <= edge_q + CNTW'(1);
                        if (last_edge) state <= S_DONE;
                    end
                end
                S_DONE: begin
                    if (!keep_q) cs_n <= 4'hF;
                    if (slot == last_ptr) begin
                        state <= S_IDLE;
                    end else begin
                        slot  <= slot + SLOTW'(1);
                        gap_q <= 1'b0;
                        state <= keep_q ? S_LOAD : S_GAP;
                    end
                end
                S_GAP: begin
                    if (tick) begin
                        if (gap_q) state <= S_LOAD;
                        gap_q <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign run     = (state == S_SHIFT) || (state == S_GAP);
    assign busy    = (state != S_IDLE);
    assign rx_we   = (state == S_DONE);
    assign fin     = rx_we && (slot == last_ptr);
    assign rx_word = rxsh & (16'hFFFF >> (CNTW'(WMAX) - nbits_q));
    assign mosi    = txsh[WMAX-1];
endmodule

// File: rtl/spi_queue_master.sv
// Queued SPI master top: register file, SCK tick generator and
// slot engine. SCK is the engine's internal phase XOR the CPOL bit.
module spi_queue_master
    import spi_q_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [8:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic [3:0]    cs_n
);
    logic             eng_busy, eng_fin, rx_we, go_pulse, run_spe, run_done;
    logic             baud_run, tick, sck_int;
    logic [SLOTW-1:0] eng_slot, first_q, last_q;
    logic [WMAX-1:0]  tx_word, rx_word;
    logic [7:0]       cmd_byte, cfg_mode;
    logic [DIVW-1:0]  div_q;

    spi_q_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .eng_fin(eng_fin), .rx_we(rx_we), .rx_slot(eng_slot), .rx_word(rx_word),
        .eng_slot(eng_slot), .tx_word(tx_word), .cmd_byte(cmd_byte),
        .div_q(div_q), .mode_q(cfg_mode), .first_q(first_q), .last_q(last_q),
        .go(go_pulse), .run_spe(run_spe), .run_done(run_done), .irq(irq)
    );

    spi_q_baud u_baud (
        .clk(clk), .rst_n(rst_n), .run(baud_run), .div_raw(div_q), .tick(tick)
    );

    spi_q_engine u_eng (
        .clk(clk), .rst_n(rst_n), .go(go_pulse), .first_ptr(first_q),
        .last_ptr(last_q), .mode(cfg_mode[5:0]), .tx_word(tx_word),
        .cmd_byte(cmd_byte), .tick(tick), .miso(miso), .run(baud_run),
        .slot(eng_slot), .rx_we(rx_we), .rx_word(rx_word), .fin(eng_fin),
        .busy(eng_busy), .sck_int(sck_int), .mosi(mosi), .cs_n(cs_n)
    );

    assign sck = sck_int ^ cfg_mode[1];
endmodule

// File: rtl/spi_queue_master_chk.sv
// Assertion checker bound into spi_queue_master.
module spi_queue_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic [3:0] cs_n,
    input logic       irq,
    input logic       busy,
    input logic       fin,
    input logic       go,
    input logic       spe,
    input logic       done,
    input logic       rx_we,
    input logic       cpol
);
    // R8
    idle_sck_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == cpol);
    // R5
    gap_sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cs_n == 4'hF) |-> sck == cpol);
    // R11
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    // R10
    fin_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (!spe && done && !busy));
    // R10
    go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
    // R8
    rx_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> busy);
endmodule

bind spi_queue_master spi_queue_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .irq(irq),
    .busy(eng_busy), .fin(eng_fin), .go(go_pulse), .spe(run_spe),
    .done(run_done), .rx_we(rx_we), .cpol(cfg_mode[1])
);

// File: tb/spi_queue_master_tb.sv
`timescale 1ns/1ps
module spi_queue_master_tb;
    localparam int CLK_P = 10;

    logic       clk = 0, rst_n = 0, reg_we = 0, miso;
    logic [8:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       irq, sck, mosi;
    logic [3:0] cs_n;

    int checks = 0, fails = 0;

    spi_queue_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_P/2) clk = !clk;

    // Slave model
    logic        s_cpol = 1, s_cpha = 1;
    logic [63:0] resp = '0, cap = '0;
    logic [3:0]  cs_log [64];
    int          nbit = 0, nsamp = 0, rises = 0, rise_n = 0;
    longint      t_first = 0, period = 0, t_up = 0, gap = 0;
    logic        cs_high_prev = 1;

    assign miso = resp[63];

    always @(sck) begin
        if (rst_n && cs_n != 4'hF) begin
            logic lead, smp;
            lead = (sck != s_cpol);
            smp  = s_cpha ? !lead : lead;
            if (smp) begin
                cap = {cap[62:0], mosi};
                if (nbit < 64) cs_log[nbit] = cs_n;
                nbit++;
                nsamp++;
            end else if (nsamp > 0) begin
                resp = resp << 1;
            end
            if (sck) begin
                if (rise_n == 0) t_first = $time;
                if (rise_n == 1) period = ($time - t_first) / CLK_P;
                rise_n++;
            end
        end
    end

    always @(cs_n) begin
        if (rst_n) begin
            if (cs_n == 4'hF && !cs_high_prev) begin
                if (s_cpha && nsamp > 0) resp = resp << 1;
                nsamp = 0;
                rises++;
                t_up = $time;
            end else if (cs_n != 4'hF && cs_high_prev && t_up != 0) begin
                gap = ($time - t_up) / CLK_P;
            end
            cs_high_prev = (cs_n == 4'hF);
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic arm(input logic cp, input logic ch, input logic [63:0] r);
        s_cpol = cp; s_cpha = ch; resp = r; cap = '0;
        nbit = 0; nsamp = 0; rises = 0; rise_n = 0; period = 0; gap = 0; t_up = 0;
    endtask

    task automatic wait_done();
        logic [7:0] st;
        for (int i = 0; i < 20000; i++) begin
            rd(9'h020, st);
            if (st[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(9'h004, v); chk("R1 mode", v, 8'hA3);
        rd(9'h020, v); chk("R1 status", v, 8'h00);
        chk("R1 cs_n", cs_n, 4'hF);
        chk("R1 sck idle", sck, 1'b1);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_single_mode0();
        logic [7:0] v;
        wr(9'h000, 8'd8);
        wr(9'h004, 8'hA0);
        wr(9'h054, 8'hA5);
        wr(9'h148, 8'h0E);
        wr(9'h010, 8'd2);
        wr(9'h014, 8'd2);
        arm(0, 0, 64'h3C << 56);
        wr(9'h018, 8'hE0);
        rd(9'h020, v); chk("R10 busy", v, 8'h02);
        wait_done();
        chk("R2 mosi msb first", cap[7:0], 8'hA5);
        rd(9'h0D4, v); chk("R8 rx low", v, 8'h3C);
        rd(9'h0D0, v); chk("R9 rx high zero", v, 8'h00);
        chk("R4 cs during slot", cs_log[0], 4'hE);
        chk("R5 cs released", cs_n, 4'hF);
        chk("R11 irq", irq, 1'b1);
        rd(9'h020, v); chk("R11 status done", v, 8'h01);
        rd(9'h018, v); chk("R10 run bit cleared", v, 8'hA0);
        chk("R7 sck period", period, 16);
        wr(9'h020, 8'h00);
        rd(9'h020, v); chk("R11 status cleared", v, 8'h00);
        chk("R11 irq cleared", irq, 1'b0);
    endtask

    task automatic t_multi_mode3();
        logic [7:0] v;
        wr(9'h000, 8'd10);
        wr(9'h004, 8'hA3);
        wr(9'h068, 8'h12); wr(9'h06C, 8'h34);
        wr(9'h070, 8'hBE); wr(9'h074, 8'hEF);
        wr(9'h078, 8'h0F); wr(9'h07C, 8'h0F);
        wr(9'h154, 8'hCD); wr(9'h158, 8'h4B); wr(9'h15C, 8'h47);
        wr(9'h010, 8'd5);
        wr(9'h014, 8'd7);
        arm(1, 1, 64'hCAFE5A5A9669 << 16);
        wr(9'h018, 8'hE0);
        wait_done();
        chk("R3 mosi stream", cap[47:0], 48'h1234BEEF0F0F);
        rd(9'h0E8, v); chk("R8 rx5 hi", v, 8'hCA);
        rd(9'h0EC, v); chk("R8 rx5 lo", v, 8'hFE);
        rd(9'h0F0, v); chk("R9 rx6 hi", v, 8'h5A);
        rd(9'h0FC, v); chk("R9 rx7 lo", v, 8'h69);
        chk("R4 cs slot5", cs_log[0], 4'hD);
        chk("R4 cs slot6", cs_log[16], 4'hB);
        chk("R4 cs slot7", cs_log[32], 4'h7);
        chk("R5 release count", rises, 2);
        chk("R5 gap at least one period", (gap >= 20), 1'b1);
        chk("R5 cs final", cs_n, 4'hF);
        wr(9'h020, 8'h00);
    endtask

    task automatic t_wrap_keep();
        logic [7:0] v;
        wr(9'h000, 8'd8);
        wr(9'h004, 8'hA1);
        wr(9'h0BC, 8'h81); wr(9'h044, 8'h7E);
        wr(9'h17C, 8'h0E); wr(9'h140, 8'h8E);
        wr(9'h010, 8'd15);
        wr(9'h014, 8'd0);
        arm(0, 1, 64'h55AA << 48);
        wr(9'h018, 8'hE0);
        wait_done();
        chk("R3 wrap stream", cap[15:0], 16'h817E);
        rd(9'h13C, v); chk("R3 rx15", v, 8'h55);
        rd(9'h0C4, v); chk("R3 rx0", v, 8'hAA);
        chk("R6 cs kept", cs_n, 4'hE);
        chk("R5 one release", rises, 1);
        wr(9'h020, 8'h00);
        rd(9'h020, v); chk("R11 cleared after wrap", v, 8'h00);
    endtask

    task automatic t_width_clamp_mode2();
        logic [7:0] v;
        wr(9'h000, 8'd3);
        wr(9'h004, 8'hB2);
        wr(9'h088, 8'h0A); wr(9'h08C, 8'hBC);
        wr(9'h164, 8'h0B);
        wr(9'h010, 8'd9);
        wr(9'h014, 8'd9);
        arm(1, 0, 64'h123 << 52);
        wr(9'h018, 8'hC0);
        wait_done();
        chk("R9 12-bit out", cap[11:0], 12'hABC);
        rd(9'h108, v); chk("R9 rx hi", v, 8'h01);
        rd(9'h10C, v); chk("R9 rx lo", v, 8'h23);
        chk("R7 clamped period", period, 16);
        chk("R11 irq masked", irq, 1'b0);
        rd(9'h020, v); chk("R11 done without irq", v, 8'h01);
        chk("R4 cs during slot", cs_log[0], 4'hB);
        chk("R8 cpol idle high", sck, 1'b1);
        chk("R5 cs released", cs_n, 4'hF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_single_mode0();
        t_multi_mode3();
        t_wrap_keep();
        t_width_clamp_mode2();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule